// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block sits in front of a DMA transfer sequencer. It collects up to four peripheral request lines, which arrive with no fixed relation to the controller clock. It brings them into the clock domain and decides which peripheral gets the system bus next. When any enabled channel has a pending request, the block asks the CPU for the bus with a hold request. It then waits until the CPU has released its drivers and answered with hold acknowledge. Only then does it pick one channel and drive that channel's active-low acknowledge line, which the peripheral also uses as its data strobe.

The winner comes from one of two priority schemes, chosen by a single mode input. In fixed mode, channel 0 always beats channel 1, channel 1 beats 2, and 2 beats 3. In rotating mode, the order starts the same way after reset. Each completed transfer then moves the channel that was just served to the bottom of the order, and its successor goes to the top. The grant stays put until the sequencer signals the end of the transfer. After that, the block either picks again or, if nothing enabled is left, releases the hold request.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is high and on the first sample after it, `hold_req` is 0 and all bits of `ack_n` are 1.
- R2: Every request bit passes through two synchroniser flops. An enabled request that is applied between clock edges makes `hold_req` read 1 after the third following rising edge.
- R3: A channel whose `chan_enable` bit is 0 never raises `hold_req` and never has its `ack_n` bit driven low, even while `hold_ack` is 1.
- R4: While `hold_ack` is 0, all bits of `ack_n` are 1.
- R5: When `hold_req` is 1 and `hold_ack` is seen at a rising edge, exactly one `ack_n` bit goes low after that edge. Bit i of `ack_n` belongs to request bit i.
- R6: With `rotate_mode` 0, the granted channel is the lowest-numbered channel that is both requesting and enabled.
- R7: With `rotate_mode` 1, the priority order begins at channel (last completed channel + 1) mod 4 and wraps upward. After reset, or after any cycle with `rotate_mode` 0, the order begins at channel 0.
- R8: Once a grant is given, `ack_n` does not change until `xfer_done` or a fall of `hold_ack`.
- R9: `xfer_done` sampled high during a grant ends it at that edge, even if `hold_ack` falls at the same edge. Rotation then advances. If enabled requests remain and `hold_ack` is 1, a new grant appears one edge later.
- R10: If `hold_ack` falls before `xfer_done`, the grant is withdrawn and rotation does not advance. When `hold_ack` returns, the same channel is granted again.
- R11: `hold_req` returns to 0 at the edge where no synchronised enabled request remains and no grant is active. This happens on the third edge after the last request is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_async | input | 4 | Peripheral request lines, asynchronous, active high |
| chan_enable | input | 4 | Per-channel enable mask, 1 = channel may be served |
| rotate_mode | input | 1 | 0 = fixed priority, 1 = rotating priority |
| hold_ack | input | 1 | CPU hold acknowledge, bus released when 1 |
| xfer_done | input | 1 | One-cycle pulse from the sequencer at end of transfer |
| hold_req | output | 1 | Bus hold request toward the CPU |
| ack_n | output | 4 | Active-low per-channel acknowledge and strobe |

## Verification
A request is due at `hold_req` three edges after it is applied: two for the synchroniser and one for the control state. Its removal takes the same three edges. A grant is due one edge after `hold_ack` is sampled high. The end of a grant shows on the edge that samples `xfer_done`, and a regrant follows one edge later. A fall of `hold_ack` masks the acknowledge lines at once. The bench drives every input at the falling edge. It waits whole cycles matching these counts, with one spare for the request path, and samples outputs at the next falling edge, so each result is read with its registers settled. Expected winners come from an arithmetic model of the rotation pointer that the bench keeps across a sweep of all request patterns, enable masks and both modes.

// File: rtl/dra_pkg.sv
package dra_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_GRANT = 2'd2
    } arb_state_e;

    // index + step, wrapped into 0 .. n-1 (step < n)
    function automatic int wrap_add(input int idx, input int step, input int n);
        int s;
        s = idx + step;
        if (s >= n) s = s - n;
        return s;
    endfunction

endpackage

// File: rtl/dra_req_sync.sv
module dra_req_sync #(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] req_in,
    output logic [NUM_CH-1:0] req_out
);
    logic [NUM_CH-1:0] stage_q [SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= req_in;
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign req_out = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/dra_prio_pick.sv
module dra_prio_pick #(
    parameter int NUM_CH = 4,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] pend,
    input  logic [IDX_W-1:0]  top,
    output logic              found,
    output logic [IDX_W-1:0]  win
);
    logic [IDX_W-1:0] cand [NUM_CH];

    for (genvar k = 0; k < NUM_CH; k++) begin : g_cand
        assign cand[k] = IDX_W'(dra_pkg::wrap_add(int'(top), k, NUM_CH));
    end

    // walk from lowest rank upward so the highest-ranked pending channel is kept last
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int k = NUM_CH - 1; k >= 0; k--) begin
            if (pend[cand[k]]) begin
                found = 1'b1;
                win   = cand[k];
            end
        end
    end
endmodule

// File: rtl/dra_arb_ctrl.sv
module dra_arb_ctrl
    import dra_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pend_any,
    input  logic              win_found,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic              hold_ack,
    input  logic              xfer_done,
    input  logic              rotate_mode,
    output logic              hold_req,
    output logic [NUM_CH-1:0] grant_vec,
    output logic [IDX_W-1:0]  top_idx
);
    arb_state_e        state_q;
    logic [NUM_CH-1:0] grant_q;
    logic [IDX_W-1:0]  gidx_q;
    logic [IDX_W-1:0]  top_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            grant_q <= '0;
            gidx_q  <= '0;
            top_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (pend_any) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (!pend_any) begin
                        state_q <= ST_IDLE;
                    end else if (hold_ack && win_found) begin
                        grant_q <= NUM_CH'(1) << win_idx;
                        gidx_q  <= win_idx;
                        state_q <= ST_GRANT;
                    end
                end
                ST_GRANT: begin
                    if (xfer_done) begin
                        grant_q <= '0;
                        top_q   <= IDX_W'(wrap_add(int'(gidx_q), 1, NUM_CH));
                        state_q <= pend_any ? ST_WAIT : ST_IDLE;
                    end else if (!hold_ack) begin
                        grant_q <= '0;
                        state_q <= pend_any ? ST_WAIT : ST_IDLE;
                    end
                end
                default: begin
                    grant_q <= '0;
                    state_q <= ST_IDLE;
                end
            endcase
            if (!rotate_mode) top_q <= '0;
        end
    end

    assign hold_req  = (state_q != ST_IDLE);
    assign grant_vec = grant_q;
    assign top_idx   = rotate_mode ? top_q : '0;
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] req_async,
    input  logic [NUM_CH-1:0] chan_enable,
    input  logic              rotate_mode,
    input  logic              hold_ack,
    input  logic              xfer_done,
    output logic              hold_req,
    output logic [NUM_CH-1:0] ack_n
);
    localparam int IDX_W = $clog2(NUM_CH);

    logic [NUM_CH-1:0] req_sync;
    logic [NUM_CH-1:0] pending;
    logic              win_found;
    logic [IDX_W-1:0]  win_idx;
    logic [IDX_W-1:0]  top_idx;
    logic [NUM_CH-1:0] grant_vec;

    dra_req_sync #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .req_in  (req_async),
        .req_out (req_sync)
    );

    assign pending = req_sync & chan_enable;

    dra_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
        .pend  (pending),
        .top   (top_idx),
        .found (win_found),
        .win   (win_idx)
    );

    dra_arb_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .pend_any    (|pending),
        .win_found   (win_found),
        .win_idx     (win_idx),
        .hold_ack    (hold_ack),
        .xfer_done   (xfer_done),
        .rotate_mode (rotate_mode),
        .hold_req    (hold_req),
        .grant_vec   (grant_vec),
        .top_idx     (top_idx)
    );

    assign ack_n = ~(grant_vec & {NUM_CH{hold_ack}});
endmodule

// File: rtl/dra_checker.sv
module dra_checker #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] chan_enable,
    input logic              hold_ack,
    input logic              xfer_done,
    input logic              hold_req,
    input logic [NUM_CH-1:0] ack_n
);
    // R4
    p_no_ack_without_hlda_r4: assert property (@(posedge clk) disable iff (rst)
        !hold_ack |-> (&ack_n));

    // R5
    p_single_grant_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ack_n));

    // R5
    p_grant_under_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(&ack_n) |-> hold_req);

    // R3
    p_masked_never_wins_r3: assert property (@(posedge clk) disable iff (rst)
        ((&$past(ack_n)) && !(&ack_n)) |-> (((~ack_n) & ~$past(chan_enable)) == '0));

    // R8
    p_grant_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (!(&ack_n) && hold_ack && !xfer_done) ##1 hold_ack |-> (ack_n == $past(ack_n)));

    // R9
    p_done_ends_grant_r9: assert property (@(posedge clk) disable iff (rst)
        (!(&ack_n) && xfer_done) |=> (&ack_n));
endmodule

bind dma_req_arbiter dra_checker #(.NUM_CH(NUM_CH)) u_dra_checker (
    .clk         (clk),
    .rst         (rst),
    .chan_enable (chan_enable),
    .hold_ack    (hold_ack),
    .xfer_done   (xfer_done),
    .hold_req    (hold_req),
    .ack_n       (ack_n)
);

// File: tb/test_dma_req_arbiter.sv
`timescale 1ns/1ps
module test_dma_req_arbiter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] req_async = '0;
    logic [3:0] chan_enable = '0;
    logic       rotate_mode = 1'b0;
    logic       hold_ack = 1'b0;
    logic       xfer_done = 1'b0;
    logic       hold_req;
    logic [3:0] ack_n;

    int n_checks = 0;
    int n_fail   = 0;
    int ptr      = 0;   // model of the rotation start channel
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dma_req_arbiter i_dma_req_arbiter (
        .clk         (clk),
        .rst         (rst),
        .req_async   (req_async),
        .chan_enable (chan_enable),
        .rotate_mode (rotate_mode),
        .hold_ack    (hold_ack),
        .xfer_done   (xfer_done),
        .hold_req    (hold_req),
        .ack_n       (ack_n)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic int pick(input logic [3:0] pend, input int start);
        for (int k = 0; k < 4; k++) begin
            int c;
            c = (start + k) % 4;
            if (pend[c]) return c;
        end
        return -1;
    endfunction

    function automatic logic [3:0] ack_of(input int ch);
        return ~(4'b0001 << ch);
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one arbitration round for a request pattern, mask and mode
    task automatic trial(input logic [3:0] r, input logic [3:0] e, input bit m);
        logic [3:0] pend;
        int g;
        pend = r & e;
        req_async = r; chan_enable = e; rotate_mode = m; hold_ack = 1'b0;
        if (!m) ptr = 0;
        cyc(2);
        chk("R2 hold not yet", {3'b0, hold_req}, 4'b0);
        cyc(2);
        chk("R2/R3 hold_req", {3'b0, hold_req}, {3'b0, |pend});
        chk("R4 no ack before hlda", ack_n, 4'hF);
        hold_ack = 1'b1;
        cyc(1);
        if (pend == 4'b0) begin
            chk("R3 masked no grant", ack_n, 4'hF);
            hold_ack = 1'b0; req_async = '0;
            cyc(4);
            return;
        end
        g = pick(pend, ptr);
        chk(m ? "R7 rotating winner" : "R6 fixed winner", ack_n, ack_of(g));
        cyc(2);
        chk("R8 grant held", ack_n, ack_of(g));
        xfer_done = 1'b1; hold_ack = 1'b0;
        #1 chk("R4 ack off with hlda low", ack_n, 4'hF);
        cyc(1);
        xfer_done = 1'b0; req_async = '0;
        if (m) ptr = (g + 1) % 4;
        chk("R9 grant ended", ack_n, 4'hF);
        cyc(4);
        chk("R11 hold dropped", {3'b0, hold_req}, 4'b0);
    endtask

    initial begin
        cyc(1);
        chk("R1 reset hold_req", {3'b0, hold_req}, 4'b0);
        chk("R1 reset ack_n", ack_n, 4'hF);
        cyc(2);
        rst = 1'b0;
        cyc(1);
        chk("R1 after reset ack_n", ack_n, 4'hF);

        for (int m = 0; m < 2; m++)
            for (int e = 0; e < 16; e++)
                for (int r = 0; r < 16; r++)
                    trial(4'(r), 4'(e), bit'(m));

        // back-to-back regrant in rotating mode, then a withdrawn grant
        begin
            int g1, g2;
            req_async = 4'b0101; chan_enable = 4'hF; rotate_mode = 1'b1;
            cyc(4);
            hold_ack = 1'b1;
            cyc(1);
            g1 = pick(4'b0101, ptr);
            chk("R7 first of pair", ack_n, ack_of(g1));
            xfer_done = 1'b1;
            cyc(1);
            xfer_done = 1'b0;
            ptr = (g1 + 1) % 4;
            chk("R9 gap after done", ack_n, 4'hF);
            chk("R9 hold kept", {3'b0, hold_req}, 4'b0001);
            cyc(1);
            g2 = pick(4'b0101, ptr);
            chk("R9 regrant rotated", ack_n, ack_of(g2));
            hold_ack = 1'b0;
            cyc(1);
            chk("R10 grant withdrawn", ack_n, 4'hF);
            hold_ack = 1'b1;
            cyc(1);
            chk("R10 same channel again", ack_n, ack_of(g2));
            hold_ack = 1'b0; req_async = '0;
            cyc(4);
            chk("R11 hold released", {3'b0, hold_req}, 4'b0);
        end

        // fixed mode after rotation restarts at channel 0
        trial(4'b1111, 4'b1111, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule